// File: doc/BRIEF.md
# Block-Access Configuration Slave for a Clock Generator

This block is a two-wire serial slave that holds six 8-bit configuration bytes for a clock generator and presents them as one flat vector to the rest of the chip. A host writes them with a block write and reads them back with a block read. Both always begin at byte 0 and run upward. Register addressing is not supported.

SCL and SDA are sampled on the fast system clock through a synchronizer. START, STOP and the SCL edges are detected from the synchronized levels. The block never drives SDA high. It raises `sda_oe` to pull the line low, either to acknowledge a byte or to send a 0 bit during a read. A write opens with a command byte and a count byte. Both are acknowledged and then thrown away. The data bytes that follow fill byte 0 upward until the host issues STOP. A read returns a count byte first and then the registers.

Top module: `cfg_block_slave`

## Requirements
- R1: After reset, byte 0 reads 0x00, bytes 1 to 4 read 0xFF and byte 5 reads 0x00. Byte i appears on `cfg_bits[8*i+7:8*i]`.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged by holding SDA low during the ninth SCL pulse. Any other address is not acknowledged, and every byte after it is ignored until the next START.
- R3: In a write, the two bytes after the address are acknowledged and discarded. Each later byte, sent MSB first, is acknowledged and stored in byte 0, byte 1 and so on, in ascending order.
- R4: A STOP after any complete byte ends loading, and bytes not reached keep their values. A byte cut off by STOP before its eighth bit changes nothing.
- R5: A data byte aimed at byte 5 is acknowledged, but byte 5 keeps its value.
- R6: Data bytes beyond the sixth are acknowledged and discarded.
- R7: A read returns the count 0x06 first, then bytes 0 to 5, each MSB first. Any byte requested after byte 5 reads 0xFF.
- R8: If the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START or STOP.
- R9: A START in the middle of any transfer restarts the address phase, and the new transfer starts again at byte 0.
- R10: `sda_oe` rises only while the synchronized SCL is low. It is low the cycle after any START or STOP.
- R11: A stored byte appears on `cfg_bits` exactly SYNC_STAGES+1 clock cycles after SCL rises for its eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the wired bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_bits | output | 48 | Configuration bytes, byte i in bits 8*i+7 to 8*i |

## Verification
The bench aims at the edges of the byte stream:
- A STOP after the first or second data byte and a STOP in the middle of a byte. A design that commits too early or too late would corrupt a neighbouring register or leave one stale.
- A write that runs past the last register. A missing guard here would overwrite the protected byte or wrap around onto byte 0.
- A read that keeps clocking after the host's NACK. A slave that misses the NACK would pull SDA low on the idle bus.
- A repeated START in the middle of a write. A counter that is not cleared would read back from the wrong byte.

Because the register outputs are compared every clock, an update one cycle early or late would also show up.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SACK,
    ST_WBYTE,
    ST_RBYTE,
    ST_MACK,
    ST_MLOAD,
    ST_HOLD
  } slv_state_e;

  // Address byte as seen on the wire: 7-bit device address then R/W bit.
  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

  // Saturating increment of a small counter.
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction

endpackage

// File: rtl/cfgslv_line_sync.sv
module cfgslv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_prev  <= scl_chain[STAGES-1];
      sda_prev  <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl  = scl_chain[STAGES-1];
  assign sda_lvl  = sda_chain[STAGES-1];
  assign ev_rise  = scl_lvl & ~scl_prev;
  assign ev_fall  = ~scl_lvl & scl_prev;
  assign ev_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign ev_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile #(
  parameter int                      NUM_REGS  = 6,
  parameter logic [8*NUM_REGS-1:0]   RESET_VAL = '0,
  parameter logic [NUM_REGS-1:0]     PROTECT   = '0,
  localparam int                     SEL_W     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [7:0]            wr_data,
  output logic [8*NUM_REGS-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (PROTECT[g]) begin : g_fixed
      assign regs_flat[8*g +: 8] = RESET_VAL[8*g +: 8];
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= RESET_VAL[8*g +: 8];
        else if (wr_en && wr_sel == SEL_W'(g))
          q <= wr_data;
      end
      assign regs_flat[8*g +: 8] = q;
    end
  end

endmodule

// File: rtl/cfgslv_engine.sv
module cfgslv_engine
  import cfgslv_pkg::*;
#(
  parameter int          NUM_REGS = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int         SEL_W    = $clog2(NUM_REGS),
  localparam int         IDX_LIM  = NUM_REGS + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_start,
  input  logic                  ev_stop,
  input  logic                  ev_rise,
  input  logic                  ev_fall,
  input  logic                  sda_lvl,
  input  logic [8*NUM_REGS-1:0] regs_flat,
  output logic                  wr_en,
  output logic [SEL_W-1:0]      wr_sel,
  output logic [7:0]            wr_data,
  output logic                  sda_oe
);

  slv_state_e st;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] idx;      // bytes done after the address byte
  logic       is_read;
  logic       ack_on;
  logic [7:0] rx_byte;
  logic [7:0] tx_next;

  // Byte to send for read position i: count first, then registers, then 0xFF.
  function automatic logic [7:0] tx_pick(input logic [7:0] i, input logic [8*NUM_REGS-1:0] r);
    int k;
    k = int'(i);
    if (k == 0) return 8'(NUM_REGS);
    else if (k <= NUM_REGS) return r[8*(k-1) +: 8];
    else return 8'hFF;
  endfunction

  assign rx_byte = {shreg[6:0], sda_lvl};
  assign tx_next = tx_pick(idx, regs_flat);

  // Data byte complete at its eighth rising SCL: write position idx-2.
  assign wr_en   = (st == ST_WBYTE) && ev_rise && (bit_cnt == 3'd7) &&
                   (idx >= 8'd2) && (idx < 8'(NUM_REGS + 2));
  assign wr_sel  = SEL_W'(idx - 8'd2);
  assign wr_data = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      idx     <= '0;
      is_read <= 1'b0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (ev_start) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      idx     <= '0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      st      <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (ev_rise) begin
          shreg   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            ack_on <= 1'b0;
            if (rx_byte == addr_byte(DEV_ADDR, 1'b0)) begin
              is_read <= 1'b0;
              st      <= ST_SACK;
            end else if (rx_byte == addr_byte(DEV_ADDR, 1'b1)) begin
              is_read <= 1'b1;
              st      <= ST_SACK;
            end else begin
              st      <= ST_HOLD;
            end
          end
        end
        ST_SACK: if (ev_fall) begin
          if (!ack_on) begin
            sda_oe <= 1'b1;
            ack_on <= 1'b1;
          end else begin
            ack_on  <= 1'b0;
            bit_cnt <= '0;
            if (is_read) begin
              shreg  <= tx_next;
              sda_oe <= ~tx_next[7];
              idx    <= sat_inc(idx, 8'(IDX_LIM));
              st     <= ST_RBYTE;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WBYTE;
            end
          end
        end
        ST_WBYTE: if (ev_rise) begin
          shreg   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            idx    <= sat_inc(idx, 8'(IDX_LIM));
            ack_on <= 1'b0;
            st     <= ST_SACK;
          end
        end
        ST_RBYTE: if (ev_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_oe <= 1'b0;
            st     <= ST_MACK;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= {shreg[6:0], 1'b0};
            sda_oe  <= ~shreg[6];
          end
        end
        ST_MACK: if (ev_rise) begin
          st <= sda_lvl ? ST_HOLD : ST_MLOAD;
        end
        ST_MLOAD: if (ev_fall) begin
          bit_cnt <= '0;
          shreg   <= tx_next;
          sda_oe  <= ~tx_next[7];
          idx     <= sat_inc(idx, 8'(IDX_LIM));
          st      <= ST_RBYTE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
  parameter int                     NUM_REGS    = 6,
  parameter int                     SYNC_STAGES = 2,
  parameter logic [6:0]             DEV_ADDR    = 7'h69,
  parameter logic [8*NUM_REGS-1:0]  RESET_VAL   = 48'h00_FF_FF_FF_FF_00,
  parameter logic [NUM_REGS-1:0]    PROTECT     = 6'b100000,
  localparam int                    CFG_W       = 8 * NUM_REGS,
  localparam int                    SEL_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [CFG_W-1:0] cfg_bits
);

  logic             scl_lvl;
  logic             sda_lvl;
  logic             ev_rise;
  logic             ev_fall;
  logic             ev_start;
  logic             ev_stop;
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [7:0]       wr_data;

  cfgslv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  cfgslv_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .sda_lvl   (sda_lvl),
    .regs_flat (cfg_bits),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  cfgslv_regfile #(
    .NUM_REGS  (NUM_REGS),
    .RESET_VAL (RESET_VAL),
    .PROTECT   (PROTECT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .regs_flat (cfg_bits)
  );

endmodule

// File: rtl/cfg_block_slave_chk.sv
module cfg_block_slave_chk #(
  parameter int CFG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             wr_en,
  input logic             sda_oe,
  input logic [CFG_W-1:0] cfg_bits
);

  // R10: the pull-down only begins while SCL is low.
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R10: SDA is released right after a STOP.
  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  // R9: a START releases SDA and restarts the transfer.
  assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  // R4: register contents only change after a completed data byte.
  assert_cfg_change_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bits) |-> $past(wr_en));

  // R3: while a host data bit is being loaded the slave is not driving.
  assert_no_drive_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sda_oe);

  // R10: the drive level does not move while SCL stays high.
  assert_oe_stable_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

endmodule

bind cfg_block_slave cfg_block_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .wr_en    (wr_en),
  .sda_oe   (sda_oe),
  .cfg_bits (cfg_bits)
);

// File: tb/tb_cfg_block_slave.sv
module tb_cfg_block_slave;

  localparam int NREG = 6;
  localparam int LAT  = 3;   // two synchronizer flops plus the write edge

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg_bits;
  wire         sda_bus = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  logic       done = 1'b0;

  logic [7:0] exp_mem [NREG];
  int         q_due [$];
  int         q_idx [$];
  logic [7:0] q_val [$];

  always #10 clk = ~clk;

  cfg_block_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .cfg_bits (cfg_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_flat();
    logic [47:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = exp_mem[i];
    return f;
  endfunction

  // Reference model: queued updates become visible LAT clocks after the SCL rise (R11).
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        exp_mem[q_idx[0]] = q_val[0];
        void'(q_due.pop_front());
        void'(q_idx.pop_front());
        void'(q_val.pop_front());
      end
      chk(cfg_bits === exp_flat(), "R11 per-clock register compare", 64'(cfg_bits), 64'(exp_flat()));
    end
  end

  task automatic tick();
    repeat (8) @(negedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  // Send a byte; widx >= 0 means the model expects it stored in that register.
  task automatic send_byte(input logic [7:0] v, input int widx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; tick();
      scl_m = 1'b1;
      if (i == 0 && widx >= 0) begin
        q_due.push_back(cyc + LAT);
        q_idx.push_back(widx);
        q_val.push_back(v);
      end
      tick(); tick();
      scl_m = 1'b0; tick();
    end
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    acked = (sda_bus == 1'b0);
    tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick();
      scl_m = 1'b1; tick();
      v[i] = sda_bus; tick();
      scl_m = 1'b0;
    end
    tick();
    sda_m = ack ? 1'b0 : 1'b1; tick();
    scl_m = 1'b1; tick(); tick();
    scl_m = 1'b0; tick();
    sda_m = 1'b1;
  endtask

  // Model target for data byte k of a write: registers only, byte 5 protected (R5, R6).
  function automatic int target(input int k);
    return (k < NREG - 1) ? k : -1;
  endfunction

  task automatic write_regs(input logic [7:0] d [], input string req);
    bit a;
    bus_start();
    send_byte(8'hD2, -1, a); chk(a, {req, " R2 write address ACK"}, 64'(a), 64'd1);
    send_byte(8'h5A, -1, a); chk(a, {req, " R3 command ACK"}, 64'(a), 64'd1);
    send_byte(8'h06, -1, a); chk(a, {req, " R3 count ACK"}, 64'(a), 64'd1);
    foreach (d[k]) begin
      send_byte(d[k], target(k), a);
      chk(a, {req, " R3 data ACK"}, 64'(a), 64'd1);
    end
    bus_stop();
  endtask

  task automatic read_regs(input int nbytes, input string req);
    bit a;
    logic [7:0] v;
    logic [7:0] e;
    bus_start();
    send_byte(8'hD3, -1, a); chk(a, {req, " R2 read address ACK"}, 64'(a), 64'd1);
    recv_byte(v, 1'b1); chk(v == 8'h06, {req, " R7 count byte"}, 64'(v), 64'h06);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(v, k != nbytes - 1);
      e = (k < NREG) ? exp_mem[k] : 8'hFF;
      chk(v == e, {req, " R7 read data byte"}, 64'(v), 64'(e));
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] v;
    exp_mem[0] = 8'h00; exp_mem[1] = 8'hFF; exp_mem[2] = 8'hFF;
    exp_mem[3] = 8'hFF; exp_mem[4] = 8'hFF; exp_mem[5] = 8'h00;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1: reset state
    chk(cfg_bits == 48'h00FFFFFFFF00, "R1 reset defaults", 64'(cfg_bits), 64'h00FFFFFFFF00);
    chk(sda_oe == 1'b0, "R1 idle no drive", 64'(sda_oe), 64'd0);
    tick();

    // R3 R5: full write of six bytes; byte 5 protected
    write_regs('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, "full");
    chk(cfg_bits[47:40] == 8'h00, "R5 protected byte unchanged", 64'(cfg_bits[47:40]), 64'h00);
    chk(cfg_bits[7:0] == 8'h11, "R3 byte0 loaded", 64'(cfg_bits[7:0]), 64'h11);
    tick();

    // R7: readback of all six bytes
    read_regs(6, "read6");
    tick();

    // R4: early STOP after two data bytes
    write_regs('{8'hA1, 8'hB2}, "early");
    chk(cfg_bits[23:16] == 8'h33, "R4 byte2 untouched after STOP", 64'(cfg_bits[23:16]), 64'h33);
    tick();

    // R4: STOP in the middle of a byte
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'hC3, 0, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); tick(); scl_m = 1'b0; tick();
    end
    bus_stop();
    tick();
    chk(cfg_bits[15:8] == 8'hB2, "R4 partial byte discarded", 64'(cfg_bits[15:8]), 64'hB2);

    // R6: nine data bytes, extras acknowledged and dropped
    write_regs('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, "long R6");
    chk(cfg_bits == 48'h000504030201, "R6 no wrap after last byte", 64'(cfg_bits), 64'h000504030201);
    tick();

    // R7: reading beyond the last register gives 0xFF
    read_regs(8, "read8");
    tick();

    // R2: wrong address is not acknowledged and the rest is ignored
    bus_start();
    send_byte(8'hA4, -1, a); chk(!a, "R2 foreign address NACK", 64'(a), 64'd0);
    send_byte(8'h5A, -1, a); chk(!a, "R2 ignored byte no ACK", 64'(a), 64'd0);
    send_byte(8'h06, -1, a); chk(!a, "R2 ignored byte no ACK", 64'(a), 64'd0);
    send_byte(8'h77, -1, a); chk(!a, "R2 ignored data no ACK", 64'(a), 64'd0);
    bus_stop();
    tick();
    chk(cfg_bits[7:0] == 8'h01, "R2 ignored data not stored", 64'(cfg_bits[7:0]), 64'h01);

    // R8: host NACKs after byte 1, then keeps clocking
    bus_start();
    send_byte(8'hD3, -1, a);
    recv_byte(v, 1'b1); chk(v == 8'h06, "R8 count before NACK", 64'(v), 64'h06);
    recv_byte(v, 1'b1); chk(v == 8'h01, "R8 byte0 before NACK", 64'(v), 64'h01);
    recv_byte(v, 1'b0); chk(v == 8'h02, "R8 byte1 NACKed", 64'(v), 64'h02);
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; tick(); scl_m = 1'b1; tick();
      chk(sda_bus == 1'b1, "R8 released after NACK", 64'(sda_bus), 64'd1);
      tick(); scl_m = 1'b0; tick();
    end
    bus_stop();
    tick();

    // R9: repeated START in a write, then a read from byte 0
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h99, 0, a);
    send_byte(8'h5B, 1, a);
    bus_start();
    send_byte(8'hD3, -1, a); chk(a, "R9 address after repeated START", 64'(a), 64'd1);
    recv_byte(v, 1'b1); chk(v == 8'h06, "R9 count after repeated START", 64'(v), 64'h06);
    recv_byte(v, 1'b0); chk(v == 8'h99, "R9 restarts at byte0", 64'(v), 64'h99);
    bus_stop();
    tick();

    // R9: repeated START in a write, new write starts at byte 0
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'hE1, 0, a);
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'hF0, 0, a);
    bus_stop();
    tick();
    chk(cfg_bits[15:0] == 16'h5BF0, "R9 second write from byte0", 64'(cfg_bits[15:0]), 64'h5BF0);
    chk(sda_oe == 1'b0, "R10 released after STOP", 64'(sda_oe), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule